// File: doc/BRIEF.md
# Interrupt Group Status Aggregator

This block gathers a parameterised set of interrupt source lines (eight by default) into one register group. Each source pulse sets a sticky raw flag. A mask register selects which raw flags are visible. Software can poll the raw or masked views, set or clear flags by writing ones, or read an index register. The index register names the most urgent visible flag and retires it as part of the read.

A small word-addressed register bus gives access. A sideband bit marks an access as coming from a debugger, so that a debugger can inspect the index without disturbing state. A two-bit line mode sets three things: whether the group is live, whether software alone retires flags, and whether a per-source hardware clear input may also retire them. The group drives one combined interrupt line.

Top module: `irq_group_agg`

## Requirements
- R1: The index register (address 1) reads 0 when no masked flag is pending. Otherwise it reads n+1, where n is the lowest-numbered pending masked flag, because a lower number has the higher priority.
- R2: A non-debug read of the index register clears the raw flag it reports on the clock edge that completes the read. The next read then shows the next pending masked flag, or 0.
- R3: A read with the debug sideband set leaves every raw flag unchanged, including the one the index reports.
- R4: The masked status (address 4) equals mask AND raw. A flag whose mask bit is 0 never appears in the index.
- R5: After reset, the mask (address 2) reads all ones, raw status (address 3) and the index read 0, and the mode (address 0) reads 1.
- R6: Writing 1 to a bit of the set register (address 5) sets that raw flag. Writing 1 to a bit of the clear register (address 6) clears it whether or not it is masked. Writing 0 bits changes nothing.
- R7: Mode encoding: 0 = line off, 1 = software retire, 2 = hardware retire, 3 = treated as off. While the line is off, source pulses are ignored. The hardware clear input retires raw flags only in mode 2 and is ignored in every other mode.
- R8: When a flag is set (by a source pulse or a set-register write) and cleared in the same cycle, the flag ends up set.
- R9: Reads of the set register, the clear register, the unmapped address 7 and all bits above the used fields return 0.
- R10: irq_out is high exactly when some masked flag is pending and the mode is 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | NSRC | Source event pulses, bit n sets raw flag n |
| hw_clr | input | NSRC | Hardware retire strobes, used in mode 2 |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_debug | input | 1 | Access comes from a debugger |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The assertions assume at most one bus access per cycle. They also assume that a debug read is never accompanied by a mode-2 hardware clear strobe on a pending flag. The bench keeps the first assumption by driving a single request per cycle. It guards the debug-read check by filtering on mode and on hw_clr. Random stimulus mixes source pulses, hardware strobes, writes to every register and both kinds of index read, so that collisions between setting and clearing come up often.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE   = 3'd0,
        A_INDEX  = 3'd1,
        A_MASK   = 3'd2,
        A_RAW    = 3'd3,
        A_MASKED = 3'd4,
        A_SET    = 3'd5,
        A_CLR    = 3'd6,
        A_NONE   = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        M_OFF = 2'd0,
        M_SW  = 2'd1,
        M_HW  = 2'd2,
        M_RSV = 2'd3
    } line_mode_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              debug;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic mode_live(line_mode_e m);
        return (m == M_SW) || (m == M_HW);
    endfunction
endpackage

// File: rtl/irqg_prio.sv
module irqg_prio #(
    parameter int NSRC  = 8,
    parameter int IDX_W = $clog2(NSRC + 1)
) (
    input  logic [NSRC-1:0]  masked,
    output logic [NSRC-1:0]  grant,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (masked[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/irqg_status.sv
module irqg_status #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] raw
);
    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst)             flag_q <= 1'b0;
            else if (set_vec[g]) flag_q <= 1'b1;
            else if (clr_vec[g]) flag_q <= 1'b0;
        end
        assign raw[g] = flag_q;

        // R8: a set in the same cycle as a clear leaves the flag set
        a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_vec[g] |=> raw[g]);
        // R2 / R6: an uncontested clear retires the flag
        a_r6_clear_takes: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[g] && !set_vec[g]) |=> !raw[g]);
    end
endmodule

// File: rtl/irqg_regbus.sv
module irqg_regbus
    import irqg_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = $clog2(NSRC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [NSRC-1:0]   raw,
    input  logic [NSRC-1:0]   masked,
    input  logic [IDX_W-1:0]  idx,
    output logic [NSRC-1:0]   mask,
    output line_mode_e        mode,
    output logic [NSRC-1:0]   wr_set,
    output logic [NSRC-1:0]   wr_clr,
    output logic              idx_take,
    output logic [DATA_W-1:0] rdata
);
    logic wr, rd;
    reg_addr_e a;
    logic [NSRC-1:0] mask_q;
    line_mode_e      mode_q;

    assign a  = reg_addr_e'(req.addr);
    assign wr = req.valid && req.write;
    assign rd = req.valid && !req.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            mode_q <= M_SW;
        end else if (wr) begin
            if (a == A_MASK) mask_q <= req.wdata[NSRC-1:0];
            if (a == A_MODE) mode_q <= line_mode_e'(req.wdata[1:0]);
        end
    end

    assign mask     = mask_q;
    assign mode     = mode_q;
    assign wr_set   = (wr && a == A_SET) ? req.wdata[NSRC-1:0] : '0;
    assign wr_clr   = (wr && a == A_CLR) ? req.wdata[NSRC-1:0] : '0;
    assign idx_take = rd && !req.debug && a == A_INDEX;

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (a)
                A_MODE:   rdata[1:0]       = mode_q;
                A_INDEX:  rdata[IDX_W-1:0] = idx;
                A_MASK:   rdata[NSRC-1:0]  = mask_q;
                A_RAW:    rdata[NSRC-1:0]  = raw;
                A_MASKED: rdata[NSRC-1:0]  = masked;
                default:  rdata            = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
    import irqg_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_evt,
    input  logic [NSRC-1:0]   hw_clr,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_debug,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int IDX_W = $clog2(NSRC + 1);

    bus_req_t        req;
    logic [NSRC-1:0] raw_q, mask_q, masked, grant;
    logic [NSRC-1:0] wr_set, wr_clr, set_all, clr_all;
    logic [IDX_W-1:0] idx_val;
    logic            idx_take, live;
    line_mode_e      mode_q;

    assign req = '{valid: bus_valid, write: bus_write, debug: bus_debug,
                   addr: bus_addr, wdata: bus_wdata};

    irqg_regbus #(.NSRC(NSRC), .IDX_W(IDX_W)) u_bus (
        .clk(clk), .rst(rst), .req(req), .raw(raw_q), .masked(masked),
        .idx(idx_val), .mask(mask_q), .mode(mode_q), .wr_set(wr_set),
        .wr_clr(wr_clr), .idx_take(idx_take), .rdata(bus_rdata));

    irqg_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) u_prio (
        .masked(masked), .grant(grant), .idx(idx_val));

    assign live    = mode_live(mode_q);
    assign masked  = raw_q & mask_q;
    assign set_all = (live ? src_evt : '0) | wr_set;
    assign clr_all = wr_clr | (idx_take ? grant : '0)
                   | ((mode_q == M_HW) ? hw_clr : '0);

    irqg_status #(.NSRC(NSRC)) u_stat (
        .clk(clk), .rst(rst), .set_vec(set_all), .clr_vec(clr_all), .raw(raw_q));

    assign irq_out = live && (|masked);

    logic dbg_idx_rd;
    assign dbg_idx_rd = bus_valid && !bus_write && bus_debug && bus_addr == A_INDEX;

    // R3: a debug index read retires nothing
    a_r3_debug_keeps: assert property (@(posedge clk) disable iff (rst)
        (dbg_idx_rd && (mode_q != M_HW || hw_clr == '0)) |=> (($past(raw_q) & ~raw_q) == '0));
    // R5: state right after reset
    a_r5_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '1 && raw_q == '0 && mode_q == M_SW));
    // R4: the index only names a masked, pending flag
    a_r4_idx_visible: assert property (@(posedge clk) disable iff (rst)
        (idx_val != '0) |-> masked[int'(idx_val) - 1]);
    // R1: no lower-numbered masked flag is pending than the one reported
    a_r1_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        (idx_val != '0) |-> ((masked & ((NSRC'(1) << (int'(idx_val) - 1)) - NSRC'(1))) == '0));
    // R1: index is zero only when nothing masked is pending
    a_r1_zero_means_idle: assert property (@(posedge clk) disable iff (rst)
        (idx_val == '0) |-> (masked == '0));
endmodule

// File: tb/tb_irq_group_agg.sv
module tb_irq_group_agg;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  src_evt, hw_clr;
    logic        bus_valid, bus_write, bus_debug;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq_out;

    int n_run = 0, n_fail = 0;
    logic [7:0] m_raw, m_mask;
    logic [1:0] m_mode;

    always #10 clk = ~clk;

    irq_group_agg dut (.clk(clk), .rst(rst), .src_evt(src_evt), .hw_clr(hw_clr),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_debug(bus_debug),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out));

    function automatic int ref_idx();
        for (int i = 0; i < 8; i++) if (m_raw[i] && m_mask[i]) return i + 1;
        return 0;
    endfunction

    function automatic logic [31:0] ref_read(logic [2:0] a);
        case (a)
            3'd0: return {30'd0, m_mode};
            3'd1: return 32'(ref_idx());
            3'd2: return {24'd0, m_mask};
            3'd3: return {24'd0, m_raw};
            3'd4: return {24'd0, m_raw & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle; entered and left at a falling edge
    task automatic cyc(string req, logic v, logic w, logic d, logic [2:0] a,
                       logic [31:0] wd, logic [7:0] s, logic [7:0] h);
        logic [7:0] setv, clrv;
        logic live;
        int ix;
        bus_valid = v; bus_write = w; bus_debug = d; bus_addr = a;
        bus_wdata = wd; src_evt = s; hw_clr = h;
        #1;
        if (v && !w) chk(req, bus_rdata, ref_read(a));
        @(posedge clk);
        live = (m_mode == 2'd1) || (m_mode == 2'd2);
        ix   = ref_idx();
        setv = (live ? s : 8'd0) | ((v && w && a == 3'd5) ? wd[7:0] : 8'd0);
        clrv = ((v && w && a == 3'd6) ? wd[7:0] : 8'd0)
             | ((m_mode == 2'd2) ? h : 8'd0);
        if (v && !w && !d && a == 3'd1 && ix != 0) clrv[ix-1] = 1'b1;
        m_raw = (m_raw & ~clrv) | setv;
        if (v && w && a == 3'd2) m_mask = wd[7:0];
        if (v && w && a == 3'd0) m_mode = wd[1:0];
        @(negedge clk);
        chk("R10 irq_out", {31'd0, irq_out},
            {31'd0, ((m_mode == 2'd1 || m_mode == 2'd2) && |(m_raw & m_mask))});
    endtask

    task automatic rd(string req, logic [2:0] a, logic d = 1'b0);
        cyc(req, 1'b1, 1'b0, d, a, 32'd0, 8'd0, 8'd0);
    endtask
    task automatic wr(string req, logic [2:0] a, logic [31:0] wd);
        cyc(req, 1'b1, 1'b1, 1'b0, a, wd, 8'd0, 8'd0);
    endtask
    task automatic pulse(string req, logic [7:0] s, logic [7:0] h);
        cyc(req, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0, s, h);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_valid = 0; bus_write = 0; bus_debug = 0; bus_addr = 0;
        bus_wdata = 0; src_evt = 0; hw_clr = 0;
        m_raw = 8'h00; m_mask = 8'hFF; m_mode = 2'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R5 reset values
        rd("R5 mask", 3'd2); rd("R5 raw", 3'd3); rd("R5 index", 3'd1); rd("R5 mode", 3'd0);
        chk("R5 raw ref", {24'd0, m_raw}, 32'd0);

        // R1/R2/R3 index sequence
        pulse("R1 src", 8'h24, 8'h00);
        rd("R1 index lowest", 3'd1, 1'b1);
        rd("R3 debug read keeps", 3'd1, 1'b1);
        rd("R3 raw after debug", 3'd3);
        rd("R2 cpu read reports 3", 3'd1);
        rd("R2 next is 6", 3'd1);
        rd("R2 then empty", 3'd1);
        rd("R2 raw empty", 3'd3);

        // R6 set/clear, R4 masking
        wr("R6 set", 3'd5, 32'h0000_0081);
        wr("R6 set zeros", 3'd5, 32'h0000_0000);
        rd("R6 raw", 3'd3);
        wr("R4 mask", 3'd2, 32'h0000_000F);
        rd("R4 masked", 3'd4);
        wr("R6 clear bit0", 3'd6, 32'h0000_0001);
        rd("R4 index hides bit7", 3'd1);
        wr("R6 clear masked bit", 3'd6, 32'h0000_0080);
        rd("R6 raw clear", 3'd3);

        // R8 set wins
        wr("R8 prep", 3'd5, 32'h0000_0010);
        cyc("R8 collide", 1'b1, 1'b1, 1'b0, 3'd6, 32'h10, 8'h10, 8'h00);
        rd("R8 raw", 3'd3);
        cyc("R8 collide set reg", 1'b1, 1'b1, 1'b0, 3'd5, 32'h02, 8'h00, 8'h00);
        wr("R8 clear", 3'd6, 32'h0000_00FF);

        // R7 modes
        pulse("R7 sw hwclr ignored a", 8'h02, 8'h00);
        pulse("R7 sw hwclr ignored b", 8'h00, 8'h02);
        rd("R7 raw mode1", 3'd3);
        wr("R7 mode2", 3'd0, 32'h0000_0002);
        pulse("R7 hw clear", 8'h00, 8'h02);
        rd("R7 raw mode2", 3'd3);
        wr("R7 mode0", 3'd0, 32'h0000_0000);
        pulse("R7 off src ignored", 8'h08, 8'h00);
        rd("R7 raw off", 3'd3);
        wr("R10 set in off", 3'd5, 32'h0000_0001);
        rd("R7 mode readback", 3'd0);
        wr("R7 mode3", 3'd0, 32'h0000_0003);
        pulse("R7 mode3 ignored", 8'h04, 8'h00);
        rd("R7 raw mode3", 3'd3);
        wr("R7 mode1", 3'd0, 32'h0000_0001);

        // R9 zero reads
        wr("R9 junk", 3'd7, 32'hFFFF_FFFF);
        rd("R9 set reg", 3'd5); rd("R9 clr reg", 3'd6); rd("R9 unmapped", 3'd7);

        // random mix, model compared every cycle
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] a;
            logic w;
            a = 3'($urandom_range(0, 7));
            w = ($urandom_range(0, 3) == 0);
            if (a == 3'd0 && w && $urandom_range(0, 3) != 0) a = 3'd1;
            cyc("R1 R2 R6 random", $urandom_range(0, 1) == 1, w,
                $urandom_range(0, 3) == 0, a, $urandom,
                8'($urandom & $urandom), 8'($urandom & $urandom & $urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule